// File: doc/BRIEF.md
# Narrow External Bus Handshake Controller

This block connects a 32-bit internal request port to an external memory bus that has a separate address bus and an 8-bit data path. A byte request becomes one external access. A half-word request becomes two byte accesses and a word request becomes four. The accesses run in ascending byte order, and only the low eight data lines carry data. In handshake mode each byte access runs until the external device raises its acknowledge. The controller then holds the access open for two more core-clock cycles and closes it.

The controller runs on the fast core clock. A one-cycle system-clock phase strobe marks the points where an access may begin. Every byte access waits for such a point before its one-cycle address phase. A small set of configuration inputs gives the bus width, the synchronous mode, the handshake mode, the memory block and the core-to-system clock ratio. A combination that is not allowed raises an error flag, and any request made while that flag is high is refused without starting a bus access.

Top module: `nbh_ctrl`

## Requirements
- R1: `cfg_err` is high when any of these holds: `cfg_bw`=1 (only 0, the 8-bit width, is supported); `cfg_ratio`=2'b11; handshake is on while `cfg_sync`=0; handshake is on for block 3 (`cfg_blk3`=1) while `cfg_ratio` is not 2'b10 (4:1). The ratio codes are 00 = 1:1, 01 = 2:1 and 10 = 4:1. A request accepted while `cfg_err` is high starts no bus access. It produces `req_done` in the next cycle, with `rd_data` at 0.
- R2: `req_size` 2'b00 gives one access at the request's address bits [1:0]. Size 2'b01 gives two accesses at {a[1],0} and then {a[1],1}. Sizes 2'b10 and 2'b11 give four accesses at 00, 01, 10 and 11, in that order. Bits [31:2] of `ext_addr` always equal those of `req_addr`.
- R3: During a write beat `ext_we_n` is low and `ext_rd_n` stays high. `ext_dout` carries `req_wdata` bits [8k+7:8k], where k is the beat index counted from 0. No two of `ext_as_n`, `ext_rd_n` and `ext_we_n` are low in the same cycle.
- R4: Every beat begins with exactly one cycle of `ext_as_n` low. The cycle before it had `sys_phase` high. In handshake mode that cycle also had `ext_ack` low.
- R5: After the address phase the read or write strobe stays low for `cfg_wait` cycles before `ext_ack` is looked at. An acknowledge raised earlier has no effect until that window ends.
- R6: In handshake mode, after the cycle in which `ext_ack` is first sampled high inside the window where it counts, the strobe stays low for exactly two more cycles and then rises. If the acknowledge is raised in strobe-low cycle a (counted from 1), the strobe is low for max(a, W+1)+2 cycles, where W is `cfg_wait`.
- R7: With handshake off, each beat keeps the strobe low for exactly W+2 cycles, and `ext_ack` is ignored.
- R8: A read beat samples `ext_din` in its final strobe-low cycle and places the byte at lane k of `rd_data` (bits [8k+7:8k]). Lanes that are not read stay 0. A write request leaves `rd_data` at 0.
- R9: `req_ready` is high only while the controller is idle. `req_done` is a one-cycle pulse in the cycle in which the strobe of the last beat has just risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bw | input | 1 | Bus width select; 0 = 8-bit |
| cfg_sync | input | 1 | Synchronous mode enable |
| cfg_hs | input | 1 | Handshake mode enable |
| cfg_blk3 | input | 1 | Target is memory block 3 |
| cfg_ratio | input | 2 | Core-to-system clock ratio code |
| cfg_wait | input | WAIT_W | Data-wait cycles before the acknowledge counts |
| cfg_err | output | 1 | Illegal configuration flag |
| sys_phase | input | 1 | One-cycle system-clock alignment strobe |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 half-word, 1x word |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 32 | Write data, right-justified |
| req_done | output | 1 | Transfer complete pulse |
| rd_data | output | 32 | Assembled read data, right-justified |
| ext_addr | output | ADDR_W | External address |
| ext_as_n | output | 1 | Address phase strobe, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Write enable for the low lane, active low |
| ext_doe | output | 1 | Data output enable |
| ext_dout | output | 8 | Write byte |
| ext_din | input | 8 | Read byte |
| ext_ack | input | 1 | Data acknowledge |

## Verification
A fault in the beat counter or the lane logic shows at the ports within one beat. The next `ext_addr` low bits arrive out of order, or the wrong write byte appears on `ext_dout` as the strobe falls. A wait or tail counter that is off by one changes the length of the strobe-low pulse of the beat it affects, so the pulse fails the max(a, W+1)+2 rule at the rising edge of that same beat. A beat that starts off its alignment point shows up in the same cycle as its address-phase strobe. A fault in read assembly stays hidden until `req_done`, when `rd_data` is compared byte by byte.

// File: rtl/nbh_pkg.sv
package nbh_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 2;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  localparam logic [1:0] RATIO_1   = 2'b00;
  localparam logic [1:0] RATIO_2   = 2'b01;
  localparam logic [1:0] RATIO_4   = 2'b10;
  localparam logic [1:0] RATIO_RSV = 2'b11;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_ADDR,
    ST_WAIT,
    ST_ACKW,
    ST_TAIL
  } nbh_state_e;

  // number of byte beats a request size expands into
  function automatic logic [LANE_W:0] beats_of(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: beats_of = 3'd1;
      SZ_HALF: beats_of = 3'd2;
      default: beats_of = 3'd4;
    endcase
  endfunction

  // lane of the first beat: byte keeps its offset, wider sizes align down
  function automatic logic [LANE_W-1:0] base_lane(input logic [1:0] sz,
                                                  input logic [LANE_W-1:0] a);
    case (sz)
      SZ_BYTE: base_lane = a;
      SZ_HALF: base_lane = {a[1], 1'b0};
      default: base_lane = '0;
    endcase
  endfunction

  // configuration legality
  function automatic logic cfg_illegal(input logic bw, input logic sync_m,
                                       input logic hs, input logic blk3,
                                       input logic [1:0] ratio);
    cfg_illegal = bw
                | (ratio == RATIO_RSV)
                | (hs & ~sync_m)
                | (hs & blk3 & (ratio != RATIO_4));
  endfunction

  // byte k of a data word
  function automatic logic [BYTE_W-1:0] lane_byte(input logic [DATA_W-1:0] w,
                                                  input logic [LANE_W-1:0] k);
    logic [DATA_W-1:0] s;
    s = w >> (BYTE_W * int'(k));
    lane_byte = s[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/nbh_cfg_check.sv
module nbh_cfg_check
  import nbh_pkg::*;
(
  input  logic       cfg_bw,
  input  logic       cfg_sync,
  input  logic       cfg_hs,
  input  logic       cfg_blk3,
  input  logic [1:0] cfg_ratio,
  output logic       cfg_err
);

  always_comb begin
    cfg_err = cfg_illegal(cfg_bw, cfg_sync, cfg_hs, cfg_blk3, cfg_ratio);
  end

endmodule

// File: rtl/nbh_beat_seq.sv
module nbh_beat_seq
  import nbh_pkg::*;
#(
  parameter int WAIT_W   = 4,
  parameter int TAIL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              cfg_hs,
  input  logic              sys_phase,
  input  logic              ext_ack,
  output nbh_state_e        state,
  output logic [LANE_W-1:0] beat_idx,
  output logic              beat_start,
  output logic              ack_take,
  output logic              beat_end,
  output logic              xfer_end,
  output logic              in_addr,
  output logic              in_strobe
);

  localparam int TAIL_W = $clog2(TAIL_CYC + 1);
  localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(TAIL_CYC - 1);

  logic [LANE_W:0]   beats_q;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] wcnt;
  logic [TAIL_W-1:0] tcnt;
  logic              hs_q;
  logic              last_beat;

  always_comb begin
    beat_start = (state == ST_SYNC) & sys_phase & ~(hs_q & ext_ack);
    ack_take   = (state == ST_ACKW) & ext_ack;
    beat_end   = (state == ST_TAIL) & (tcnt == TAIL_LAST);
    last_beat  = ({1'b0, beat_idx} == (beats_q - 3'd1));
    xfer_end   = beat_end & last_beat;
    in_addr    = (state == ST_ADDR);
    in_strobe  = (state == ST_WAIT) | (state == ST_ACKW) | (state == ST_TAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat_idx <= '0;
      beats_q  <= '0;
      wait_q   <= '0;
      wcnt     <= '0;
      tcnt     <= '0;
      hs_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            beats_q  <= beats_of(size);
            wait_q   <= cfg_wait;
            hs_q     <= cfg_hs;
            beat_idx <= '0;
            state    <= ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (beat_start) state <= ST_ADDR;
        end
        ST_ADDR: begin
          wcnt <= wait_q;
          tcnt <= '0;
          if (wait_q != '0)  state <= ST_WAIT;
          else if (hs_q)     state <= ST_ACKW;
          else               state <= ST_TAIL;
        end
        ST_WAIT: begin
          wcnt <= wcnt - WAIT_W'(1);
          if (wcnt == WAIT_W'(1)) state <= hs_q ? ST_ACKW : ST_TAIL;
        end
        ST_ACKW: begin
          if (ack_take) state <= ST_TAIL;
        end
        ST_TAIL: begin
          if (beat_end) begin
            if (last_beat) begin
              state <= ST_IDLE;
            end else begin
              beat_idx <= beat_idx + LANE_W'(1);
              state    <= ST_SYNC;
            end
          end else begin
            tcnt <= tcnt + TAIL_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nbh_rd_pack.sv
module nbh_rd_pack
  import nbh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap,
  input  logic [LANE_W-1:0] lane,
  input  logic [BYTE_W-1:0] din,
  output logic [DATA_W-1:0] rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              lane_q <= '0;
      else if (clear)                          lane_q <= '0;
      else if (cap && (lane == LANE_W'(g)))    lane_q <= din;
    end
    assign rd_data[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/nbh_ctrl.sv
module nbh_ctrl
  import nbh_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WAIT_W   = 4,
  parameter int TAIL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bw,
  input  logic              cfg_sync,
  input  logic              cfg_hs,
  input  logic              cfg_blk3,
  input  logic [1:0]        cfg_ratio,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              cfg_err,
  input  logic              sys_phase,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_done,
  output logic [31:0]       rd_data,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_as_n,
  output logic              ext_rd_n,
  output logic              ext_we_n,
  output logic              ext_doe,
  output logic [7:0]        ext_dout,
  input  logic [7:0]        ext_din,
  input  logic              ext_ack
);

  nbh_state_e        state;
  logic [LANE_W-1:0] beat_idx;
  logic              beat_start, ack_take, beat_end, xfer_end;
  logic              in_addr, in_strobe;
  logic              accept, start, reject;
  logic              wr_q, done_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wdata_q;

  nbh_cfg_check u_cfg (
    .cfg_bw    (cfg_bw),
    .cfg_sync  (cfg_sync),
    .cfg_hs    (cfg_hs),
    .cfg_blk3  (cfg_blk3),
    .cfg_ratio (cfg_ratio),
    .cfg_err   (cfg_err)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign start     = accept & ~cfg_err;
  assign reject    = accept & cfg_err;

  nbh_beat_seq #(.WAIT_W(WAIT_W), .TAIL_CYC(TAIL_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .size       (req_size),
    .cfg_wait   (cfg_wait),
    .cfg_hs     (cfg_hs),
    .sys_phase  (sys_phase),
    .ext_ack    (ext_ack),
    .state      (state),
    .beat_idx   (beat_idx),
    .beat_start (beat_start),
    .ack_take   (ack_take),
    .beat_end   (beat_end),
    .xfer_end   (xfer_end),
    .in_addr    (in_addr),
    .in_strobe  (in_strobe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      base_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= xfer_end | reject;
      if (start) begin
        wr_q    <= req_write;
        base_q  <= {req_addr[ADDR_W-1:LANE_W],
                    base_lane(req_size, req_addr[LANE_W-1:0])};
        wdata_q <= req_wdata;
      end
    end
  end

  nbh_rd_pack u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .cap     (beat_end & ~wr_q),
    .lane    (beat_idx),
    .din     (ext_din),
    .rd_data (rd_data)
  );

  assign req_done = done_q;
  assign ext_addr = {base_q[ADDR_W-1:LANE_W], base_q[LANE_W-1:0] | beat_idx};
  assign ext_as_n = ~in_addr;
  assign ext_rd_n = ~(in_strobe & ~wr_q);
  assign ext_we_n = ~(in_strobe & wr_q);
  assign ext_doe  = wr_q & (in_addr | in_strobe);
  assign ext_dout = lane_byte(wdata_q, beat_idx);

endmodule

// File: rtl/nbh_sva.sv
module nbh_sva #(
  parameter int TAIL_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_phase,
  input logic       ext_as_n,
  input logic       ext_rd_n,
  input logic       ext_we_n,
  input logic [1:0] ext_addr_lo,
  input logic       req_done,
  input logic       ack_take,
  input logic       beat_end,
  input logic       xfer_end
);

  logic [7:0] since_ack;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_ack <= '0;
    else if (ack_take)       since_ack <= 8'd1;
    else if (beat_end)       since_ack <= '0;
    else if (since_ack != 0) since_ack <= since_ack + 8'd1;
  end

  // R3
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ext_as_n, ~ext_rd_n, ~ext_we_n}));

  // R4
  a_r4_phase_align: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_as_n) |-> $past(sys_phase));

  // R6
  a_r6_tail_len: assert property (@(posedge clk) disable iff (!rst_n)
    (since_ack == 8'(TAIL_CYC)) |-> beat_end);

  // R6
  a_r6_strobe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end |=> (ext_rd_n & ext_we_n));

  // R2
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_end & ~xfer_end) |=> (ext_addr_lo == $past(ext_addr_lo) + 2'd1));

  // R9
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

endmodule

bind nbh_ctrl nbh_sva #(.TAIL_CYC(TAIL_CYC)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_phase   (sys_phase),
  .ext_as_n    (ext_as_n),
  .ext_rd_n    (ext_rd_n),
  .ext_we_n    (ext_we_n),
  .ext_addr_lo (ext_addr[1:0]),
  .req_done    (req_done),
  .ack_take    (ack_take),
  .beat_end    (beat_end),
  .xfer_end    (xfer_end)
);

// File: tb/nbh_ctrl_tb.sv
`timescale 1ns/1ps
module nbh_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bw = 0, cfg_sync = 1, cfg_hs = 1, cfg_blk3 = 0;
  logic [1:0]  cfg_ratio = 2'b10;
  logic [3:0]  cfg_wait = 4'd1;
  logic        cfg_err;
  logic        sys_phase = 0;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic        req_done;
  logic [31:0] rd_data;
  logic [31:0] ext_addr;
  logic        ext_as_n, ext_rd_n, ext_we_n, ext_doe;
  logic [7:0]  ext_dout, ext_din;
  logic        ext_ack = 0;

  always #4 clk = ~clk;

  nbh_ctrl u_dut (.*);

  logic [7:0] mem [0:255];
  assign ext_din = mem[ext_addr[7:0]];

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] q_addr[$];
  logic [7:0]  q_wb[$];
  int  n_low = 0, ack_at = 0, pcnt = 0, beats_total = 0;
  bit  prev_strobe = 0, was_wr = 0, rise_now = 0, early = 0;
  logic [31:0] cur_addr;
  logic [7:0]  cur_wb;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic int ratio_n();
    return (cfg_ratio == 2'b00) ? 1 : (cfg_ratio == 2'b01) ? 2 : 4;
  endfunction

  // memory model and per-clock protocol reference
  always @(negedge clk) begin
    bit strobe;
    int w, exp_len;
    if (!rst_n) begin
      n_low = 0; prev_strobe = 0; rise_now = 0; ext_ack = 0; sys_phase = 0; pcnt = 0;
    end else begin
      strobe = !ext_rd_n || !ext_we_n;
      w = int'(cfg_wait);
      if (!ext_as_n) begin
        chk(sys_phase == 1'b1, "R4 address phase after alignment strobe", sys_phase, 1);
        if (cfg_hs) chk(ext_ack == 1'b0, "R4 acknowledge low before beat", ext_ack, 0);
        beats_total++;
      end
      if (strobe) begin
        n_low++;
        if (n_low == 1) begin
          cur_addr = ext_addr;
          was_wr = !ext_we_n;
          if (q_addr.size() > 0) begin
            chk(ext_addr == q_addr[0], "R2 beat address", ext_addr, q_addr[0]);
            void'(q_addr.pop_front());
          end else chk(0, "R2 unexpected beat", ext_addr, 0);
          if (was_wr) begin
            chk(ext_dout == q_wb[0] && ext_doe && ext_rd_n, "R3 write byte", ext_dout, q_wb[0]);
            cur_wb = ext_dout;
            void'(q_wb.pop_front());
          end
          if (early) ack_at = 1;
          else if (cfg_hs) ack_at = w + $urandom_range(1, 3);
          else ack_at = 0;
        end
        if (n_low == ack_at) ext_ack = 1;
      end else if (prev_strobe) begin
        if (cfg_hs) begin
          exp_len = ((ack_at > w + 1) ? ack_at : w + 1) + 2;
          chk(n_low == exp_len, "R6 strobe low length", n_low, exp_len);
          if (early) chk(n_low == exp_len, "R5 early acknowledge ignored", n_low, exp_len);
        end else begin
          chk(n_low == w + 2, "R7 strobe low length without handshake", n_low, w + 2);
        end
        if (was_wr) mem[cur_addr[7:0]] = cur_wb;
        ext_ack = 0;
        n_low = 0;
      end
      rise_now = prev_strobe && !strobe;
      prev_strobe = strobe;
      pcnt = (pcnt + 1) % ratio_n();
      sys_phase = (pcnt == 0);
    end
  end

  task automatic xfer(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                      input logic [31:0] wd);
    int nb, to;
    logic [1:0] bl;
    logic [31:0] exp_rd;
    nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    bl = (sz == 2'b00) ? addr[1:0] : (sz == 2'b01) ? {addr[1], 1'b0} : 2'b00;
    exp_rd = 0;
    for (int k = 0; k < nb; k++) begin
      logic [31:0] a;
      a = {addr[31:2], bl | 2'(k)};
      q_addr.push_back(a);
      if (wr) q_wb.push_back(wd[8*k +: 8]);
      else exp_rd[8*k +: 8] = mem[a[7:0]];
    end
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R9 ready while idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    @(negedge clk); #1;
    req_valid = 0;
    chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
    to = 0;
    while (!req_done && to < 3000) begin
      @(negedge clk); #1;
      to++;
    end
    chk(req_done == 1'b1, "R9 transfer completes", req_done, 1);
    chk(rise_now == 1'b1, "R9 done with final strobe rise", rise_now, 1);
    chk(rd_data == exp_rd, "R8 read data", rd_data, exp_rd);
    chk(q_addr.size() == 0, "R2 beat count", q_addr.size(), 0);
    @(negedge clk); #1;
    chk(req_done == 1'b0, "R9 done is one cycle", req_done, 0);
  endtask

  task automatic reject_xfer(input string why);
    int b0;
    b0 = beats_total;
    @(negedge clk); #1;
    chk(cfg_err == 1'b1, {"R1 error flag: ", why}, cfg_err, 1);
    req_valid = 1; req_write = 0; req_size = 2'b10; req_addr = 32'h10;
    @(negedge clk); #1;
    req_valid = 0;
    chk(req_done == 1'b1, "R1 refused request completes next cycle", req_done, 1);
    chk(rd_data == 0, "R1 refused request read data", rd_data, 0);
    repeat (6) @(negedge clk);
    #1;
    chk(beats_total == b0 && ext_rd_n && ext_we_n, "R1 no bus access", beats_total, b0);
  endtask

  task automatic set_cfg(input bit bw, input bit sy, input bit hs, input bit b3,
                         input logic [1:0] ra, input logic [3:0] w, input bit er);
    @(negedge clk); #1;
    cfg_bw = bw; cfg_sync = sy; cfg_hs = hs; cfg_blk3 = b3; cfg_ratio = ra;
    cfg_wait = w; early = er;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37) ^ 8'h5a);
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1 && ext_rd_n && ext_we_n && ext_as_n && !req_done && rd_data == 0,
        "R9 reset state", {req_ready, ext_rd_n, ext_we_n}, 3'b111);
    chk(cfg_err == 0, "R1 legal default configuration", cfg_err, 0);
    rst_n = 1;

    // handshake reads, 4:1 ratio
    set_cfg(0, 1, 1, 1, 2'b10, 4'd1, 0);
    xfer(0, 2'b10, 32'h0000_0040, 0);
    xfer(0, 2'b01, 32'h0000_0016, 0);
    xfer(0, 2'b00, 32'h0000_0023, 0);
    xfer(0, 2'b11, 32'h0000_0031, 0);
    // writes then read back
    set_cfg(0, 1, 1, 0, 2'b01, 4'd2, 0);
    xfer(1, 2'b10, 32'h0000_0080, 32'hA1B2C3D4);
    xfer(0, 2'b10, 32'h0000_0080, 0);
    set_cfg(0, 1, 1, 0, 2'b00, 4'd0, 0);
    xfer(1, 2'b01, 32'h0000_0093, 32'h0000_7E3C);
    xfer(1, 2'b00, 32'h0000_00A2, 32'h0000_00E5);
    xfer(0, 2'b10, 32'h0000_0090, 0);
    xfer(0, 2'b00, 32'h0000_00A2, 0);
    // early acknowledge before window
    set_cfg(0, 1, 1, 1, 2'b10, 4'd3, 1);
    xfer(0, 2'b10, 32'h0000_0050, 0);
    xfer(1, 2'b01, 32'h0000_0054, 32'h0000_1234);
    // handshake off, acknowledge toggled early and ignored
    set_cfg(0, 0, 0, 0, 2'b01, 4'd2, 1);
    xfer(0, 2'b10, 32'h0000_0060, 0);
    set_cfg(0, 1, 0, 1, 2'b00, 4'd0, 0);
    xfer(0, 2'b01, 32'h0000_0066, 0);
    // illegal configurations
    set_cfg(0, 1, 1, 1, 2'b01, 4'd1, 0);
    reject_xfer("block 3 at 2:1");
    set_cfg(0, 1, 1, 1, 2'b00, 4'd1, 0);
    reject_xfer("block 3 at 1:1");
    set_cfg(0, 0, 1, 0, 2'b10, 4'd1, 0);
    reject_xfer("handshake without sync");
    set_cfg(1, 1, 1, 0, 2'b10, 4'd1, 0);
    reject_xfer("wide bus");
    set_cfg(0, 1, 0, 0, 2'b11, 4'd1, 0);
    reject_xfer("reserved ratio");
    set_cfg(0, 1, 1, 0, 2'b01, 4'd1, 0);
    @(negedge clk); #1;
    chk(cfg_err == 0, "R1 block 2 at 2:1 is legal", cfg_err, 0);
    xfer(0, 2'b10, 32'h0000_0070, 0);

    summary();
    $finish;
  end

endmodule